// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a register-mapped watchdog. Software programs a reload value, a 16-bit down-count, a linear prescale factor and a power-of-two divide ratio. Once the run bit is set, the clock passes through the 8-bit prescaler and then through the selectable divider. Each resulting tick lowers the counter by one. When the counter reaches zero, the block latches an interrupt, starts a fixed-length reset-request pulse, or does both, depending on two independent enable bits. On the following tick it refills the counter from the reload register. Firmware keeps the system alive by rewriting the counter before it runs out.

Control comes from a small sequencer with three named states. HALT is entered whenever the run bit is low, and the counter holds its value there. RUN is the counting state. WRAP is the state in which the counter sits at zero and waits for the refill tick. The transitions are as follows. Start (HALT to RUN) happens when run goes high. Expire (RUN to WRAP) happens on a tick that finds the count at 1 or 0. Refill (WRAP to RUN) happens on the next tick. Kick (WRAP to RUN) happens on a software write to the counter. Stop (RUN or WRAP to HALT) happens when run goes low. The bus uses single-cycle write strobes and a read strobe. Read data is returned one cycle after the read strobe, together with a valid flag.

Top module: `wdt_prescaled`

## Requirements
- R1: After reset, the control word is 0, the reload and counter registers read 0x8000, and both irq_o and rst_req_o are low.
- R2: The registers are decoded from address bits [3:2]: 0x0 control, 0x4 reload, 0x8 live counter, 0xC interrupt clear (this one reads 0). In the control word, bit 0 enables the reset request, bit 2 enables the interrupt, bits [4:3] select the divider, bit 5 is run and bits [15:8] hold the prescale value P. All other control bits read 0. bus_rvalid and bus_rdata appear one cycle after bus_rd.
- R3: Ticks come every (P+1)·2^(4+sel) clocks. The prescale and divide counters clear while run is low, so the first tick after run rises comes one full period later.
- R4: While run is 1, each tick lowers the counter by one. While run is 0, the counter holds.
- R5: A tick that finds the count at 1 (or 0) leaves the counter at 0. The next tick loads the reload value.
- R6: If the interrupt enable is set, the tick that reaches zero sets irq_o on that clock edge, and irq_o stays high until it is cleared.
- R7: Writing 0xC with bit 0 set drops irq_o on the next edge. A write with bit 0 clear has no effect. If an expiry and a clear fall in the same cycle, the expiry wins.
- R8: If the reset enable is set, expiry drives rst_req_o high for exactly RST_CYCLES clocks, starting at the expiry edge.
- R9: An expiry with its enable bit clear produces no interrupt or no reset request, and the counter still wraps.
- R10: A counter write loads the written value on the next edge. It takes priority over a tick and cancels a pending refill.
- R11: With run cleared the timer stops, so no expiry occurs and no reset request is issued, even with the reset enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 2 | Word address (byte offset bits [3:2]) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_o | output | 1 | Latched expiry interrupt |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The reset-width check assumes that two expiries are never closer together than RST_CYCLES clocks. Because an expiry and its refill each take a full tick period of at least 16 clocks, this holds whenever RST_CYCLES is below 16 and software does not keep writing counts of 0 or 1. The bench uses the default pulse length and always loads counts of 2 or more. The decrement and hold properties assume that the bus never issues a write and a read to the counter in conflicting ways. The bench drives only one strobe at a time, and only at the falling edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int BUS_W = 16;
    localparam int PRE_W = 8;
    localparam int SEL_W = 2;

    localparam logic [1:0] IDX_CTRL  = 2'd0;
    localparam logic [1:0] IDX_LOAD  = 2'd1;
    localparam logic [1:0] IDX_COUNT = 2'd2;
    localparam logic [1:0] IDX_CLEAR = 2'd3;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_WRAP = 2'd2
    } wdt_state_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [SEL_W-1:0] div_sel;
        logic             run;
        logic             irq_en;
        logic             rst_en;
    } wdt_ctrl_t;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter logic [BUS_W-1:0] LOAD_INIT = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       idx,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] count_val,
    output wdt_ctrl_t        ctrl,
    output logic [BUS_W-1:0] reload,
    output logic             count_wr,
    output logic             clear_wr,
    output logic [BUS_W-1:0] rdata,
    output logic             rvalid
);
    logic [BUS_W-1:0] rd_mux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl   <= '0;
            reload <= LOAD_INIT;
        end else if (wr_en) begin
            if (idx == IDX_CTRL) begin
                ctrl.pre     <= wdata[15:8];
                ctrl.run     <= wdata[5];
                ctrl.div_sel <= wdata[4:3];
                ctrl.irq_en  <= wdata[2];
                ctrl.rst_en  <= wdata[0];
            end
            if (idx == IDX_LOAD) reload <= wdata;
        end
    end

    assign count_wr = wr_en && (idx == IDX_COUNT);
    assign clear_wr = wr_en && (idx == IDX_CLEAR) && wdata[0];

    always_comb begin
        unique case (idx)
            IDX_CTRL:  rd_mux = {ctrl.pre, 2'b00, ctrl.run, ctrl.div_sel,
                                 ctrl.irq_en, 1'b0, ctrl.rst_en};
            IDX_LOAD:  rd_mux = reload;
            IDX_COUNT: rd_mux = count_val;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_W     = 8,
    parameter int SEL_W     = 2,
    parameter int BASE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int DIV_W = BASE_LOG2 + (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] mask;
    logic             stage1;

    assign stage1 = run && (pre_cnt >= pre);

    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
        assign mask[i] = (i < (BASE_LOG2 + int'(div_sel)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (!run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (stage1) begin
            pre_cnt <= '0;
            div_cnt <= div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assign tick = stage1 && ((div_cnt & mask) == mask);
endmodule

// File: rtl/wdt_sequencer.sv
module wdt_sequencer
    import wdt_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter int               RST_CYCLES = 4,
    parameter logic [CNT_W-1:0] CNT_INIT   = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             irq_en,
    input  logic             rst_en,
    input  logic             count_wr,
    input  logic             clear_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output wdt_state_e       state,
    output logic             expire,
    output logic             irq_o,
    output logic             rst_req_o
);
    localparam int PW = $clog2(RST_CYCLES + 1);
    localparam logic [PW-1:0] PULSE_LEN = PW'(RST_CYCLES);

    wdt_state_e      nxt;
    logic [PW-1:0]   pulse_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HALT: if (run) nxt = ST_RUN;
            ST_RUN: begin
                if (!run)                               nxt = ST_HALT;
                else if (count_wr)                      nxt = ST_RUN;
                else if (tick && (count <= CNT_W'(1)))  nxt = ST_WRAP;
            end
            ST_WRAP: begin
                if (!run)                  nxt = ST_HALT;
                else if (count_wr || tick) nxt = ST_RUN;
            end
            default: nxt = ST_HALT;
        endcase
    end

    assign expire = (state == ST_RUN) && run && tick && !count_wr &&
                    (count <= CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= CNT_INIT;
        end else if (count_wr) begin
            count <= wdata;
        end else if (run && tick) begin
            if (state == ST_WRAP)                             count <= reload;
            else if (state == ST_RUN && count != '0)          count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            pulse_cnt <= '0;
        end else begin
            if (expire && irq_en) irq_o <= 1'b1;
            else if (clear_wr)    irq_o <= 1'b0;
            if (expire && rst_en)     pulse_cnt <= PULSE_LEN;
            else if (pulse_cnt != '0) pulse_cnt <= pulse_cnt - 1'b1;
        end
    end

    assign rst_req_o = (pulse_cnt != '0);
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
    import wdt_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:2]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              irq_o,
    output logic              rst_req_o
);
    wdt_ctrl_t        ctrl;
    logic [BUS_W-1:0] reload;
    logic [BUS_W-1:0] count;
    logic             count_wr;
    logic             clear_wr;
    logic             tick;
    logic             expire;
    wdt_state_e       state;
    logic             run_w;
    logic             irq_en_w;
    logic             rst_en_w;

    assign run_w    = ctrl.run;
    assign irq_en_w = ctrl.irq_en;
    assign rst_en_w = ctrl.rst_en;

    wdt_regfile #(.LOAD_INIT(16'h8000)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
        .idx(bus_addr), .wdata(bus_wdata), .count_val(count),
        .ctrl(ctrl), .reload(reload), .count_wr(count_wr),
        .clear_wr(clear_wr), .rdata(bus_rdata), .rvalid(bus_rvalid)
    );

    wdt_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W), .BASE_LOG2(4)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_w), .pre(ctrl.pre),
        .div_sel(ctrl.div_sel), .tick(tick)
    );

    wdt_sequencer #(.CNT_W(BUS_W), .RST_CYCLES(RST_CYCLES), .CNT_INIT(16'h8000)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run_w), .tick(tick),
        .irq_en(irq_en_w), .rst_en(rst_en_w), .count_wr(count_wr),
        .clear_wr(clear_wr), .wdata(bus_wdata), .reload(reload),
        .count(count), .state(state), .expire(expire),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );
endmodule

// File: rtl/wdt_prescaled_chk.sv
module wdt_prescaled_chk
    import wdt_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_o,
    input logic        rst_req_o,
    input logic        irq_en,
    input logic        rst_en,
    input logic        run,
    input logic        tick,
    input logic        count_wr,
    input logic        clear_wr,
    input logic        expire,
    input logic [15:0] wdata,
    input logic [15:0] count,
    input wdt_state_e  state
);
    logic [15:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_len <= '0;
        else if (rst_req_o) hi_len <= hi_len + 1'b1;
        else                hi_len <= '0;
    end

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(irq_en));

    assert_rst_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> ($past(rst_en) && $past(run)));

    assert_rst_not_long_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (hi_len < 16'(RST_CYCLES)));

    assert_rst_full_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_o) |-> ($past(hi_len) == 16'(RST_CYCLES - 1)));

    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_wr && !expire) |=> !irq_o);

    assert_kick_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count_wr |=> (count == $past(wdata)));

    assert_halt_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !count_wr) |=> $stable(count));

    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && run && tick && !count_wr && count > 16'd1)
        |=> (count == $past(count) - 16'd1));
endmodule

bind wdt_prescaled wdt_prescaled_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .rst_req_o(rst_req_o),
    .irq_en(irq_en_w), .rst_en(rst_en_w), .run(run_w), .tick(tick),
    .count_wr(count_wr), .clear_wr(clear_wr), .expire(expire),
    .wdata(bus_wdata), .count(count), .state(state)
);

// File: tb/wdt_prescaled_tb.sv
`timescale 1ns/1ps
module wdt_prescaled_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:2]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic        irq_o;
    logic        rst_req_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_prescaled #(.RST_CYCLES(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    // Monitor: pops the scoreboard whenever read data comes back
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected read data: actual %h expected none", bus_rdata);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic chk_pin(input string t, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", t, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = idx; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, input logic [15:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_rd = 1'b1; bus_addr = idx;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        int e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: reset state and decode
        chk_pin("R1 irq after reset", irq_o, 1'b0);
        chk_pin("R1 rst_req after reset", rst_req_o, 1'b0);
        rd(2'd0, 16'h0000, "R1 control reset");
        rd(2'd1, 16'h8000, "R1 reload reset");
        rd(2'd2, 16'h8000, "R1 counter reset");
        rd(2'd3, 16'h0000, "R2 clear register reads zero");
        wr(2'd0, 16'hA4DF);
        rd(2'd0, 16'hA41D, "R2 control fields masked");
        wr(2'd0, 16'h0000);

        // P=0, div16, irq only
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd3);
        wr(2'd0, 16'h0024);
        e = cyc;
        wait_until(e + 8);  rd(2'd2, 16'd3, "R4 count before first tick");
        wait_until(e + 24); rd(2'd2, 16'd2, "R3 R4 first decrement after 16");
        wait_until(e + 40); rd(2'd2, 16'd1, "R4 second decrement");
        wait_until(e + 47); chk_pin("R6 no irq before zero", irq_o, 1'b0);
        wait_until(e + 48); chk_pin("R6 irq at expiry", irq_o, 1'b1);
        chk_pin("R9 no reset request when disabled", rst_req_o, 1'b0);
        wait_until(e + 50); rd(2'd2, 16'd0, "R5 counter held at zero");
        wait_until(e + 66); rd(2'd2, 16'd3, "R5 refill from reload");
        wait_until(e + 70); chk_pin("R6 irq stays latched", irq_o, 1'b1);
        wait_until(e + 72); wr(2'd3, 16'h0000);
        chk_pin("R7 clear with bit0 low ignored", irq_o, 1'b1);
        wr(2'd3, 16'h0001);
        chk_pin("R7 clear drops irq", irq_o, 1'b0);
        wait_until(e + 84); wr(2'd0, 16'h0004);
        wait_until(e + 200); rd(2'd2, 16'd2, "R4 R11 count holds when stopped");
        chk_pin("R11 no irq while stopped", irq_o, 1'b0);

        // P=2, div32, reset only: period 96
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd2);
        wr(2'd0, 16'h0229);
        e = cyc;
        wait_until(e + 94); rd(2'd2, 16'd2, "R3 no tick before full period");
        wait_until(e + 97); rd(2'd2, 16'd1, "R3 tick after (P+1)*32");
        wait_until(e + 191); chk_pin("R8 no pulse before expiry", rst_req_o, 1'b0);
        wait_until(e + 192); chk_pin("R8 pulse starts", rst_req_o, 1'b1);
        chk_pin("R9 no irq when disabled", irq_o, 1'b0);
        wait_until(e + 195); chk_pin("R8 pulse last cycle", rst_req_o, 1'b1);
        wait_until(e + 196); chk_pin("R8 pulse width", rst_req_o, 1'b0);
        wait_until(e + 200); wr(2'd2, 16'd9);
        rd(2'd2, 16'd9, "R10 kick loads counter");
        wait_until(e + 290); rd(2'd2, 16'd8, "R10 kick cancels refill");
        wait_until(e + 300); wr(2'd2, 16'd5);
        wait_until(e + 386); rd(2'd2, 16'd4, "R10 counting after kick");
        wait_until(e + 481); chk_pin("R10 kick prevents expiry", rst_req_o, 1'b0);
        wait_until(e + 500); wr(2'd0, 16'h0001);
        wait_until(e + 1000);
        chk_pin("R11 no reset request with run low", rst_req_o, 1'b0);
        rd(2'd2, 16'd3, "R11 count frozen");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 missing read data: actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        summary();
        $finish;
    end
endmodule